// File: doc/BRIEF.md
# SIMT Divergence Stack Controller

This block keeps the divergence stack of a single wavefront. Every stack level holds a program counter, the program counter at which the diverged paths join again, and an execution mask with one bit per lane. The top level is the current execution context, and it drives the current PC, the join PC and the active-lane mask. Branch logic pushes a new level when lanes diverge. After each executed instruction the execute stage reports whether the instruction redirected the PC. The block then either moves to the next sequential PC, pops a path that has reached its join point, or takes the new target. It tells the instruction buffer whether to retire its oldest entry or to flush everything.

To switch a wavefront out, a save port drains the stack one entry per cycle, top level first, and always emits exactly one slot per lane. Slots after the live levels are filled with all-ones sentinels. A restore port accepts slots one per cycle in push order and discards sentinels, which rebuilds the stack. Both ports use a valid/ready handshake.

Top module: `simt_reconv_stack`

## Requirements
- R1: While the stack is empty, `stack_valid` is 0 and `cur_pc`, `cur_rpc` and `cur_mask` are 0. Otherwise those three outputs show the fields of the top level.
- R2: A push with a nonzero mask puts a new level on top, and that level is visible in the next cycle. A push with an all-zero mask leaves the stack unchanged and raises `err_zero_mask` for one cycle after the push.
- R3: The stack holds LANES levels. A push while all levels are in use and no pop happens in the same cycle leaves the stack unchanged and raises `err_overflow` for one cycle after the push.
- R4: An executed instruction with `exec_redirect`=0 whose sequential next PC (current PC + PC_STEP) differs from the top join PC writes that next PC into the top level only. `retire_buf` then pulses in the next cycle.
- R5: An executed instruction with `exec_redirect`=0 whose sequential next PC equals the top join PC pops the top level. `flush_buf` then pulses in the next cycle.
- R6: An executed instruction with `exec_redirect`=1 writes `exec_target` into the top level's PC. `flush_buf` then pulses in the next cycle. `flush_buf` and `retire_buf` are never high together.
- R7: `drop_fetch` becomes 1 after a flush only if `fetch_pending` was 1 in the executing cycle. It returns to 0 after a cycle with `fetch_return`=1 and no new flush.
- R8: An executed instruction while the stack is empty changes nothing and raises `err_underflow` for one cycle, with no flush and no retire.
- R9: A save, started by a `save_start` pulse, emits exactly LANES slots. The live levels come first, top level first, and each is popped on its handshake. The remaining slots have PC, join PC and mask all ones. The stack is empty at the end.
- R10: Each restore slot accepted while `rs_ready` is 1 is pushed in arrival order, except a slot whose PC is all ones, which is skipped.
- R11: While a save is in progress, `push_valid` and `exec_valid` have no effect and `rs_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push a new divergence level |
| push_pc | input | PC_W | PC of the pushed level |
| push_rpc | input | PC_W | Join PC of the pushed level |
| push_mask | input | LANES | Lane mask of the pushed level |
| exec_valid | input | 1 | An instruction of the top path executed this cycle |
| exec_redirect | input | 1 | That instruction changed the PC |
| exec_target | input | PC_W | New PC when redirected |
| fetch_pending | input | 1 | A fetch request is outstanding |
| fetch_return | input | 1 | The outstanding fetch came back |
| cur_pc | output | PC_W | Top level PC |
| cur_rpc | output | PC_W | Top level join PC |
| cur_mask | output | LANES | Top level active-lane mask |
| stack_valid | output | 1 | Stack holds at least one level |
| flush_buf | output | 1 | Flush the instruction buffer |
| retire_buf | output | 1 | Retire the oldest buffered instruction |
| drop_fetch | output | 1 | Discard the in-flight fetch when it returns |
| err_zero_mask | output | 1 | Push with an empty mask was rejected |
| err_overflow | output | 1 | Push on a full stack was rejected |
| err_underflow | output | 1 | Execute on an empty stack was rejected |
| save_start | input | 1 | Begin a context save |
| save_valid | output | 1 | Save slot available |
| save_ready | input | 1 | Consumer takes the save slot |
| save_pc | output | PC_W | Save slot PC |
| save_rpc | output | PC_W | Save slot join PC |
| save_mask | output | LANES | Save slot mask |
| rs_valid | input | 1 | Restore slot offered |
| rs_ready | output | 1 | Restore slot accepted |
| rs_pc | input | PC_W | Restore slot PC |
| rs_rpc | input | PC_W | Restore slot join PC |
| rs_mask | input | LANES | Restore slot mask |

## Verification
The hardest case to reach is a save that starts with the stack partly full, so that live levels and sentinel slots appear in the same drain. Other inputs also have to arrive while the save is busy. The stimulus first builds two levels through the restore port, with a sentinel placed between them. It then starts a save and holds `save_ready` low for one cycle while driving a redirect and a push, which must have no effect. Only then does it drain all eight slots. A separate run fills the stack to its limit before saving, so every slot in that drain is live.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Outcome of one executed instruction on the top level
    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_ADVANCE  = 2'd1,
        ACT_POP      = 2'd2,
        ACT_REDIRECT = 2'd3
    } act_e;

    // Buffer-side consequence of an action
    function automatic logic act_flushes(act_e a);
        return (a == ACT_POP) || (a == ACT_REDIRECT);
    endfunction

endpackage

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int LANES = 8,
    parameter int PC_W  = 16,
    parameter int DEPTH = LANES,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             wr_pc,
    input  logic [PC_W-1:0]  wr_pc_val,
    input  logic             push,
    input  logic [PC_W-1:0]  push_pc,
    input  logic [PC_W-1:0]  push_rpc,
    input  logic [LANES-1:0] push_mask,
    output logic [PC_W-1:0]  top_pc,
    output logic [PC_W-1:0]  top_rpc,
    output logic [LANES-1:0] top_mask,
    output logic [CNT_W-1:0] depth
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0]  pc_all   [DEPTH];
    logic [PC_W-1:0]  rpc_all  [DEPTH];
    logic [LANES-1:0] mask_all [DEPTH];
    logic [CNT_W-1:0] push_idx;
    logic [CNT_W-1:0] top_idx;

    // A push lands above whatever remains after a same-cycle pop
    assign push_idx = depth - CNT_W'(pop);
    assign top_idx  = depth - CNT_W'(1);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PC_W-1:0]  pc_r;
        logic [PC_W-1:0]  rpc_r;
        logic [LANES-1:0] mask_r;

        always_ff @(posedge clk) begin
            if (push && push_idx == CNT_W'(g)) begin
                pc_r   <= push_pc;
                rpc_r  <= push_rpc;
                mask_r <= push_mask;
            end else if (wr_pc && depth != '0 && top_idx == CNT_W'(g)) begin
                pc_r <= wr_pc_val;
            end
        end

        assign pc_all[g]   = pc_r;
        assign rpc_all[g]  = rpc_r;
        assign mask_all[g] = mask_r;
    end

    always_ff @(posedge clk) begin
        if (rst) depth <= '0;
        else     depth <= depth - CNT_W'(pop) + CNT_W'(push);
    end

    always_comb begin
        top_pc   = '0;
        top_rpc  = '0;
        top_mask = '0;
        if (depth != '0) begin
            top_pc   = pc_all[top_idx[IDX_W-1:0]];
            top_rpc  = rpc_all[top_idx[IDX_W-1:0]];
            top_mask = mask_all[top_idx[IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/rstk_seq.sv
module rstk_seq
    import rstk_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int PC_STEP = 4
) (
    input  logic            enable,
    input  logic            exec_valid,
    input  logic            exec_redirect,
    input  logic [PC_W-1:0] exec_target,
    input  logic            stack_valid,
    input  logic [PC_W-1:0] top_pc,
    input  logic [PC_W-1:0] top_rpc,
    output act_e            act,
    output logic [PC_W-1:0] new_pc,
    output logic            underflow
);
    logic [PC_W-1:0] seq_pc;

    assign seq_pc    = top_pc + PC_W'(PC_STEP);
    assign underflow = enable && exec_valid && !stack_valid;
    assign new_pc    = exec_redirect ? exec_target : seq_pc;

    always_comb begin
        act = ACT_NONE;
        if (enable && exec_valid && stack_valid) begin
            if (exec_redirect)         act = ACT_REDIRECT;
            else if (seq_pc == top_rpc) act = ACT_POP;
            else                       act = ACT_ADVANCE;
        end
    end
endmodule

// File: rtl/rstk_save.sv
module rstk_save #(
    parameter int LANES = 8,
    localparam int SLOT_W = $clog2(LANES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic save_start,
    input  logic save_ready,
    input  logic stack_valid,
    output logic busy,
    output logic pop
);
    logic [SLOT_W-1:0] slot_q;
    logic              fire;

    assign fire = busy && save_ready;
    assign pop  = fire && stack_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            slot_q <= '0;
        end else if (!busy) begin
            busy   <= save_start;
            slot_q <= '0;
        end else if (fire) begin
            if (slot_q == SLOT_W'(LANES - 1)) begin
                busy   <= 1'b0;
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import rstk_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int PC_W    = 16,
    parameter int PC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic [PC_W-1:0]  push_pc,
    input  logic [PC_W-1:0]  push_rpc,
    input  logic [LANES-1:0] push_mask,
    input  logic             exec_valid,
    input  logic             exec_redirect,
    input  logic [PC_W-1:0]  exec_target,
    input  logic             fetch_pending,
    input  logic             fetch_return,
    output logic [PC_W-1:0]  cur_pc,
    output logic [PC_W-1:0]  cur_rpc,
    output logic [LANES-1:0] cur_mask,
    output logic             stack_valid,
    output logic             flush_buf,
    output logic             retire_buf,
    output logic             drop_fetch,
    output logic             err_zero_mask,
    output logic             err_overflow,
    output logic             err_underflow,
    input  logic             save_start,
    output logic             save_valid,
    input  logic             save_ready,
    output logic [PC_W-1:0]  save_pc,
    output logic [PC_W-1:0]  save_rpc,
    output logic [LANES-1:0] save_mask,
    input  logic             rs_valid,
    output logic             rs_ready,
    input  logic [PC_W-1:0]  rs_pc,
    input  logic [PC_W-1:0]  rs_rpc,
    input  logic [LANES-1:0] rs_mask
);
    localparam int DEPTH = LANES;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] depth;
    logic [PC_W-1:0]  top_pc, top_rpc, new_pc;
    logic [LANES-1:0] top_mask;
    logic             save_busy, save_pop, underflow;
    act_e             act;

    logic             req_push, full, push_do, pop_any, wr_any;
    logic [PC_W-1:0]  req_pc, req_rpc;
    logic [LANES-1:0] req_mask;

    assign stack_valid = (depth != '0);

    rstk_seq #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_seq (
        .enable(!save_busy), .exec_valid(exec_valid),
        .exec_redirect(exec_redirect), .exec_target(exec_target),
        .stack_valid(stack_valid), .top_pc(top_pc), .top_rpc(top_rpc),
        .act(act), .new_pc(new_pc), .underflow(underflow)
    );

    rstk_save #(.LANES(LANES)) u_save (
        .clk(clk), .rst(rst), .save_start(save_start),
        .save_ready(save_ready), .stack_valid(stack_valid),
        .busy(save_busy), .pop(save_pop)
    );

    // Push source: branch port first, restore port only when it is idle
    assign rs_ready = !save_busy && !push_valid;
    always_comb begin
        if (push_valid) begin
            req_push = !save_busy;
            req_pc   = push_pc;
            req_rpc  = push_rpc;
            req_mask = push_mask;
        end else begin
            req_push = rs_valid && rs_ready && (rs_pc != {PC_W{1'b1}});
            req_pc   = rs_pc;
            req_rpc  = rs_rpc;
            req_mask = rs_mask;
        end
    end

    assign pop_any = (act == ACT_POP) || save_pop;
    assign wr_any  = (act == ACT_ADVANCE) || (act == ACT_REDIRECT);
    assign full    = (depth == CNT_W'(DEPTH)) && !pop_any;
    assign push_do = req_push && (req_mask != '0) && !full;

    rstk_store #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .pop(pop_any),
        .wr_pc(wr_any), .wr_pc_val(new_pc),
        .push(push_do), .push_pc(req_pc), .push_rpc(req_rpc),
        .push_mask(req_mask),
        .top_pc(top_pc), .top_rpc(top_rpc), .top_mask(top_mask),
        .depth(depth)
    );

    assign cur_pc   = top_pc;
    assign cur_rpc  = top_rpc;
    assign cur_mask = top_mask;

    assign save_valid = save_busy;
    assign save_pc    = stack_valid ? top_pc   : {PC_W{1'b1}};
    assign save_rpc   = stack_valid ? top_rpc  : {PC_W{1'b1}};
    assign save_mask  = stack_valid ? top_mask : {LANES{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_buf     <= 1'b0;
            retire_buf    <= 1'b0;
            drop_fetch    <= 1'b0;
            err_zero_mask <= 1'b0;
            err_overflow  <= 1'b0;
            err_underflow <= 1'b0;
        end else begin
            flush_buf     <= act_flushes(act);
            retire_buf    <= (act == ACT_ADVANCE);
            err_zero_mask <= req_push && (req_mask == '0);
            err_overflow  <= req_push && (req_mask != '0) && full;
            err_underflow <= underflow;
            if (act_flushes(act) && fetch_pending) drop_fetch <= 1'b1;
            else if (fetch_return)                  drop_fetch <= 1'b0;
        end
    end
endmodule

// File: rtl/rstk_checker.sv
module rstk_checker #(
    parameter int LANES = 8,
    parameter int PC_W  = 16,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             push_valid,
    input logic [LANES-1:0] push_mask,
    input logic             exec_valid,
    input logic             exec_redirect,
    input logic             fetch_pending,
    input logic             stack_valid,
    input logic             flush_buf,
    input logic             retire_buf,
    input logic             drop_fetch,
    input logic             err_zero_mask,
    input logic             err_overflow,
    input logic             err_underflow,
    input logic             save_valid,
    input logic [PC_W-1:0]  save_pc,
    input logic             rs_ready,
    input logic             save_busy,
    input logic [CNT_W-1:0] depth
);
    p_zero_mask_r2: assert property (@(posedge clk) disable iff (rst)
        push_valid && push_mask == '0 && !save_busy |=> err_zero_mask);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        push_valid && push_mask != '0 && depth == CNT_W'(LANES) && !exec_valid && !save_busy
        |=> err_overflow && depth == CNT_W'(LANES));

    p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
        !(flush_buf && retire_buf));

    p_redirect_flush_r6: assert property (@(posedge clk) disable iff (rst)
        exec_valid && exec_redirect && stack_valid && !save_busy |=> flush_buf);

    p_drop_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(drop_fetch) |-> $past(fetch_pending));

    p_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        exec_valid && !stack_valid && !save_busy |=> err_underflow && !flush_buf && !retire_buf);

    p_sentinel_r9: assert property (@(posedge clk) disable iff (rst)
        save_valid && !stack_valid |-> save_pc == {PC_W{1'b1}});

    p_save_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        save_busy |-> !rs_ready);
endmodule

bind simt_reconv_stack rstk_checker #(.LANES(LANES), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_mask(push_mask),
    .exec_valid(exec_valid), .exec_redirect(exec_redirect),
    .fetch_pending(fetch_pending), .stack_valid(stack_valid),
    .flush_buf(flush_buf), .retire_buf(retire_buf), .drop_fetch(drop_fetch),
    .err_zero_mask(err_zero_mask), .err_overflow(err_overflow),
    .err_underflow(err_underflow), .save_valid(save_valid), .save_pc(save_pc),
    .rs_ready(rs_ready), .save_busy(save_busy), .depth(depth)
);

// File: tb/simt_reconv_stack_tb.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb;
    localparam int LANES = 8;
    localparam int PC_W  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic             push_valid = 0, exec_valid = 0, exec_redirect = 0;
    logic [PC_W-1:0]  push_pc = 0, push_rpc = 0, exec_target = 0;
    logic [LANES-1:0] push_mask = 0;
    logic             fetch_pending = 0, fetch_return = 0;
    logic             save_start = 0, save_ready = 0, rs_valid = 0;
    logic [PC_W-1:0]  rs_pc = 0, rs_rpc = 0;
    logic [LANES-1:0] rs_mask = 0;
    logic [PC_W-1:0]  cur_pc, cur_rpc, save_pc, save_rpc;
    logic [LANES-1:0] cur_mask, save_mask;
    logic stack_valid, flush_buf, retire_buf, drop_fetch;
    logic err_zero_mask, err_overflow, err_underflow, save_valid, rs_ready;

    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .PC_STEP(4)) u_dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_pc(push_pc),
        .push_rpc(push_rpc), .push_mask(push_mask), .exec_valid(exec_valid),
        .exec_redirect(exec_redirect), .exec_target(exec_target),
        .fetch_pending(fetch_pending), .fetch_return(fetch_return),
        .cur_pc(cur_pc), .cur_rpc(cur_rpc), .cur_mask(cur_mask),
        .stack_valid(stack_valid), .flush_buf(flush_buf), .retire_buf(retire_buf),
        .drop_fetch(drop_fetch), .err_zero_mask(err_zero_mask),
        .err_overflow(err_overflow), .err_underflow(err_underflow),
        .save_start(save_start), .save_valid(save_valid), .save_ready(save_ready),
        .save_pc(save_pc), .save_rpc(save_rpc), .save_mask(save_mask),
        .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc),
        .rs_rpc(rs_rpc), .rs_mask(rs_mask)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_top(input string req, input logic [15:0] p, input logic [15:0] r,
                           input logic [7:0] m);
        chk({req, " pc"}, 32'(cur_pc), 32'(p));
        chk({req, " rpc"}, 32'(cur_rpc), 32'(r));
        chk({req, " mask"}, 32'(cur_mask), 32'(m));
    endtask

    task automatic do_push(input logic [15:0] p, input logic [15:0] r, input logic [7:0] m);
        push_valid = 1; push_pc = p; push_rpc = r; push_mask = m;
        tick();
        push_valid = 0;
    endtask

    task automatic do_exec(input logic redir, input logic [15:0] t);
        exec_valid = 1; exec_redirect = redir; exec_target = t;
        tick();
        exec_valid = 0; exec_redirect = 0;
    endtask

    task automatic do_restore(input logic [15:0] p, input logic [15:0] r, input logic [7:0] m);
        rs_valid = 1; rs_pc = p; rs_rpc = r; rs_mask = m;
        #1;
        chk("R10 rs_ready", 32'(rs_ready), 32'd1);
        tick();
        rs_valid = 0;
    endtask

    task automatic chk_slot(input int k, input logic [15:0] p, input logic [15:0] r,
                            input logic [7:0] m);
        chk($sformatf("R9 slot%0d valid", k), 32'(save_valid), 32'd1);
        chk($sformatf("R9 slot%0d pc", k), 32'(save_pc), 32'(p));
        chk($sformatf("R9 slot%0d rpc", k), 32'(save_rpc), 32'(r));
        chk($sformatf("R9 slot%0d mask", k), 32'(save_mask), 32'(m));
        tick();
    endtask

    // Vector table: op 0 push, 1 sequential execute, 2 redirected execute
    localparam int NV = 9;
    localparam logic [1:0]  V_OP  [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd1, 2'd0, 2'd2, 2'd1};
    localparam logic [15:0] V_PC  [NV] = '{16'h0100, 16'h0200, 16'h0, 16'h0104, 16'h0, 16'h0,
                                           16'h0300, 16'h0100, 16'h0};
    localparam logic [15:0] V_RPC [NV] = '{16'hFFF0, 16'h0108, 16'h0, 16'h0, 16'h0, 16'h0,
                                           16'h0104, 16'h0, 16'h0};
    localparam logic [7:0]  V_MSK [NV] = '{8'hFF, 8'h0F, 8'h0, 8'h0, 8'h0, 8'h0, 8'hF0, 8'h0, 8'h0};
    localparam logic [15:0] E_PC  [NV] = '{16'h0100, 16'h0200, 16'h0204, 16'h0104, 16'h0100,
                                           16'h0104, 16'h0300, 16'h0100, 16'h0104};
    localparam logic [15:0] E_RPC [NV] = '{16'hFFF0, 16'h0108, 16'h0108, 16'h0108, 16'hFFF0,
                                           16'hFFF0, 16'h0104, 16'h0104, 16'hFFF0};
    localparam logic [7:0]  E_MSK [NV] = '{8'hFF, 8'h0F, 8'h0F, 8'h0F, 8'hFF, 8'hFF, 8'hF0,
                                           8'hF0, 8'hFF};
    localparam logic        E_FL  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic        E_RT  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // R1: reset state
        chk("R1 reset stack_valid", 32'(stack_valid), 32'd0);
        chk_top("R1 reset", 16'h0, 16'h0, 8'h0);
        chk("R7 reset drop", 32'(drop_fetch), 32'd0);
        chk("R9 reset save_valid", 32'(save_valid), 32'd0);

        // R8: execute on empty stack
        do_exec(1'b1, 16'h0400);
        chk("R8 underflow", 32'(err_underflow), 32'd1);
        chk("R8 no flush", 32'(flush_buf), 32'd0);
        chk("R8 still empty", 32'(stack_valid), 32'd0);

        // R2 R4 R5 R6: table walk
        for (int i = 0; i < NV; i++) begin
            if (V_OP[i] == 2'd0) do_push(V_PC[i], V_RPC[i], V_MSK[i]);
            else                 do_exec(V_OP[i] == 2'd2, V_PC[i]);
            chk_top($sformatf("R4/R5/R6 vec%0d", i), E_PC[i], E_RPC[i], E_MSK[i]);
            chk($sformatf("R5 R6 vec%0d flush", i), 32'(flush_buf), 32'(E_FL[i]));
            chk($sformatf("R4 vec%0d retire", i), 32'(retire_buf), 32'(E_RT[i]));
        end

        // R2: zero-mask push rejected
        do_push(16'h0900, 16'h0990, 8'h00);
        chk("R2 zero mask err", 32'(err_zero_mask), 32'd1);
        chk_top("R2 unchanged", 16'h0104, 16'hFFF0, 8'hFF);

        // R7: drop flag only with a pending fetch
        fetch_pending = 1;
        do_exec(1'b1, 16'h0200);
        chk("R7 flush", 32'(flush_buf), 32'd1);
        chk("R7 drop set", 32'(drop_fetch), 32'd1);
        fetch_pending = 0; fetch_return = 1;
        tick();
        fetch_return = 0;
        chk("R7 drop cleared", 32'(drop_fetch), 32'd0);
        do_exec(1'b1, 16'h0104);
        chk("R7 flush no pending", 32'(flush_buf), 32'd1);
        chk("R7 drop stays low", 32'(drop_fetch), 32'd0);
        fetch_pending = 1;
        do_exec(1'b0, 16'h0);
        chk("R7 retire keeps drop low", 32'(drop_fetch), 32'd0);
        chk("R4 retire", 32'(retire_buf), 32'd1);
        fetch_pending = 0;
        do_exec(1'b1, 16'h0104);

        // R3: fill to LANES levels, then overflow
        for (int i = 0; i < LANES - 1; i++)
            do_push(16'h1000 + 16'(i * 16), 16'h2000, 8'(i + 1));
        chk_top("R3 full top", 16'h1060, 16'h2000, 8'h07);
        do_push(16'h5000, 16'h5010, 8'h01);
        chk("R3 overflow err", 32'(err_overflow), 32'd1);
        chk_top("R3 top unchanged", 16'h1060, 16'h2000, 8'h07);

        // R9: save of a full stack
        save_start = 1;
        tick();
        save_start = 0;
        save_ready = 1;
        for (int k = 0; k < LANES - 1; k++)
            chk_slot(k, 16'h1000 + 16'((LANES - 2 - k) * 16), 16'h2000, 8'(LANES - 1 - k));
        chk_slot(LANES - 1, 16'h0104, 16'hFFF0, 8'hFF);
        save_ready = 0;
        chk("R9 drained", 32'(stack_valid), 32'd0);
        chk("R9 save done", 32'(save_valid), 32'd0);

        // R10: restore with an interleaved sentinel
        do_restore(16'h0A00, 16'hFFF0, 8'hFF);
        chk_top("R10 first", 16'h0A00, 16'hFFF0, 8'hFF);
        do_restore(16'hFFFF, 16'hFFFF, 8'hFF);
        chk_top("R10 sentinel skipped", 16'h0A00, 16'hFFF0, 8'hFF);
        do_restore(16'h0B00, 16'h0A10, 8'h3C);
        chk_top("R10 second", 16'h0B00, 16'h0A10, 8'h3C);

        // R11: inputs ignored while saving; R9: partial drain with sentinels
        save_start = 1;
        tick();
        save_start = 0;
        exec_valid = 1; exec_redirect = 1; exec_target = 16'h7777;
        push_valid = 1; push_pc = 16'h6000; push_rpc = 16'h6010; push_mask = 8'h01;
        #1;
        chk("R11 rs_ready low", 32'(rs_ready), 32'd0);
        tick();
        exec_valid = 0; exec_redirect = 0; push_valid = 0;
        chk("R11 no flush", 32'(flush_buf), 32'd0);
        chk("R11 no zero/overflow", 32'(err_overflow | err_zero_mask), 32'd0);
        save_ready = 1;
        chk_slot(0, 16'h0B00, 16'h0A10, 8'h3C);
        chk_slot(1, 16'h0A00, 16'hFFF0, 8'hFF);
        for (int k = 2; k < LANES; k++)
            chk_slot(k, 16'hFFFF, 16'hFFFF, 8'hFF);
        save_ready = 0;
        chk("R9 partial drained", 32'(stack_valid), 32'd0);
        chk("R9 partial done", 32'(save_valid), 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule